// File: doc/BRIEF.md
# Stereo Audio Transmit FIFO with Threshold DMA Request

This block buffers outgoing stereo audio between a bus or DMA master and a serial audio transmitter. Each word written holds one stereo frame. The left sample sits in bits 15:0 and the right sample in bits 31:16. The FIFO stores 16 such words in a RAM that synthesis can map to block RAM. It hands samples to the serializer one halfword at a time, left first and then right.

A DMA request is raised while the number of free slots is at or above a programmable level. A level of four lets a DMA engine top up the FIFO in bursts of up to four words without overrunning it. The request falls in the same cycle that the free count drops below the level. A transmit-enable input gates only the draining side, so software can prefill the FIFO before playback begins. A clear input empties the FIFO at once. The free count and the empty flag are outputs, so a stop sequence can wait for the FIFO to drain.

Top module: `audio_tx_fifo`

## Requirements
- R1: After reset, empty is 1, free_count is 16, overflow, underflow and sample_valid are 0.
- R2: A write while the FIFO is not full and clear is low stores the word. free_count then falls by one and empty goes to 0 after the clock edge that takes the write.
- R3: Each enabled pop yields one sample with sample_valid high in the following cycle. Samples come out in write order, with bits 15:0 (sample_right=0) first and then bits 31:16 (sample_right=1) of each word.
- R4: dma_req is 1 exactly when free_count >= cfg_level, in the same cycle.
- R5: A write to a full FIFO is dropped and never appears at the output. It sets the sticky overflow flag.
- R6: A left-phase pop while enabled and empty outputs a zero left sample and then, on the next pop, a zero right sample. It sets the sticky underflow flag and leaves free_count unchanged.
- R7: A pop while cfg_enable is 0 is ignored: no sample_valid, and no change of free_count. Writes are still accepted.
- R8: cfg_clear empties the FIFO, clears both sticky flags and returns the output phase to left. A write in the same cycle is dropped without setting overflow.
- R9: A write and a left-phase pop in the same cycle on a non-empty, non-full FIFO leave free_count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Allows the serializer to drain the FIFO |
| cfg_clear | input | 1 | Empties the FIFO and clears the flags |
| cfg_level | input | 5 | Free-slot level for the DMA request |
| wr_valid | input | 1 | Write strobe |
| wr_data | input | 32 | Stereo word: left in 15:0, right in 31:16 |
| ser_pop | input | 1 | Serializer asks for the next sample |
| sample_out | output | 16 | Sample delivered to the serializer |
| sample_right | output | 1 | 1 when sample_out is the right channel |
| sample_valid | output | 1 | sample_out is valid this cycle |
| free_count | output | 5 | Number of free word slots |
| empty | output | 1 | FIFO holds no words |
| dma_req | output | 1 | Request for more data |
| overflow | output | 1 | Sticky: a write to a full FIFO was dropped |
| underflow | output | 1 | Sticky: a pop found the FIFO empty |

## Verification
A wrong occupancy count shows at free_count and dma_req one cycle after the write or pop that caused it. It also shows later as a dropped or repeated word at the sample output. A wrong read pointer or phase bit shows as a sample out of order or a swapped channel tag on the first pop after the fault. The scoreboard catches this on that sample. A clear or underflow path that fails to reset state shows on the first pop after the event, as a stale right half or a non-zero sample.

// File: rtl/atf_pkg.sv
package atf_pkg;
  typedef enum logic {
    PH_LEFT  = 1'b0,
    PH_RIGHT = 1'b1
  } half_phase_t;
endpackage

// File: rtl/atf_ram.sv
module atf_ram #(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/atf_occupancy.sv
module atf_occupancy #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr_req,
  input  logic          rd_req,
  output logic          wr_ok,
  output logic          rd_ok,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] free_q,
  output logic          empty_q,
  output logic          ovf_q
);
  logic full;
  logic [CW-1:0] free_nx;

  assign full  = (free_q == '0);
  assign wr_ok = wr_req && !full && !clr;
  assign rd_ok = rd_req && !empty_q && !clr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    free_nx = free_q;
    if (wr_ok && !rd_ok) free_nx = free_q - CW'(1);
    else if (rd_ok && !wr_ok) free_nx = free_q + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      free_q  <= CW'(DEPTH);
      empty_q <= 1'b1;
      ovf_q   <= 1'b0;
    end else begin
      if (wr_ok) wr_ptr <= bump(wr_ptr);
      if (rd_ok) rd_ptr <= bump(rd_ptr);
      free_q  <= free_nx;
      empty_q <= (free_nx == CW'(DEPTH));
      if (wr_req && full) ovf_q <= 1'b1;
    end
  end

  // R2
  free_bound_chk: assert property (@(posedge clk) disable iff (rst)
    free_q <= CW'(DEPTH));

  // R9
  free_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(clr) |-> (free_q == $past(free_q) ||
                     free_q == $past(free_q) + CW'(1) ||
                     free_q + CW'(1) == $past(free_q)));

  // R5
  ovf_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_q) |-> $past(wr_req && free_q == '0));

  // R1
  empty_free_chk: assert property (@(posedge clk) disable iff (rst)
    empty_q == (free_q == CW'(DEPTH)));
endmodule

// File: rtl/atf_unpack.sv
module atf_unpack #(
  parameter int DW  = 32,
  localparam int HW = DW / 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          en,
  input  logic          pop,
  input  logic          fifo_empty,
  input  logic [DW-1:0] rdata,
  output logic          rd_req,
  output logic [HW-1:0] sample,
  output logic          sample_right,
  output logic          sample_valid,
  output logic          unf_q
);
  import atf_pkg::*;

  half_phase_t phase_q;
  logic        zero_q;
  logic        take;

  assign take   = pop && en && !clr;
  assign rd_req = take && (phase_q == PH_LEFT);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      phase_q      <= PH_LEFT;
      zero_q       <= 1'b0;
      sample_valid <= 1'b0;
      sample_right <= 1'b0;
      unf_q        <= 1'b0;
    end else begin
      sample_valid <= take;
      if (take) begin
        if (phase_q == PH_LEFT) begin
          phase_q      <= PH_RIGHT;
          sample_right <= 1'b0;
          zero_q       <= fifo_empty;
          if (fifo_empty) unf_q <= 1'b1;
        end else begin
          phase_q      <= PH_LEFT;
          sample_right <= 1'b1;
        end
      end
    end
  end

  assign sample = zero_q ? '0 : (sample_right ? rdata[DW-1:HW] : rdata[HW-1:0]);

  // R7
  valid_cause_chk: assert property (@(posedge clk) disable iff (rst)
    sample_valid |-> $past(pop && en));

  // R6
  unf_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (take && phase_q == PH_LEFT && fifo_empty) |=> (sample_valid && sample == '0));

  // R3
  alt_phase_chk: assert property (@(posedge clk) disable iff (rst)
    (take && phase_q == PH_RIGHT) |=> (sample_valid && sample_right));
endmodule

// File: rtl/audio_tx_fifo.sv
module audio_tx_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int HW   = DW / 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_enable,
  input  logic          cfg_clear,
  input  logic [CW-1:0] cfg_level,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  input  logic          ser_pop,
  output logic [HW-1:0] sample_out,
  output logic          sample_right,
  output logic          sample_valid,
  output logic [CW-1:0] free_count,
  output logic          empty,
  output logic          dma_req,
  output logic          overflow,
  output logic          underflow
);
  logic          wr_ok, rd_ok, rd_req;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [DW-1:0] rdata;

  atf_occupancy #(.DEPTH(DEPTH)) u_occ (
    .clk(clk), .rst(rst), .clr(cfg_clear),
    .wr_req(wr_valid), .rd_req(rd_req),
    .wr_ok(wr_ok), .rd_ok(rd_ok),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .free_q(free_count), .empty_q(empty), .ovf_q(overflow)
  );

  atf_ram #(.DEPTH(DEPTH), .DW(DW)) u_ram (
    .clk(clk), .we(wr_ok), .waddr(wr_ptr), .wdata(wr_data),
    .re(rd_ok), .raddr(rd_ptr), .rdata(rdata)
  );

  atf_unpack #(.DW(DW)) u_unp (
    .clk(clk), .rst(rst), .clr(cfg_clear), .en(cfg_enable),
    .pop(ser_pop), .fifo_empty(empty), .rdata(rdata),
    .rd_req(rd_req), .sample(sample_out), .sample_right(sample_right),
    .sample_valid(sample_valid), .unf_q(underflow)
  );

  assign dma_req = (free_count >= cfg_level);

  // R4
  req_drop_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(dma_req) && $stable(cfg_level) && free_count < $past(free_count)
     && free_count < cfg_level) |-> !dma_req);

  // R8
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_clear) |-> (empty && !overflow && !underflow && !sample_valid));
endmodule

// File: tb/sim_audio_tx_fifo.sv
module sim_audio_tx_fifo;
  localparam int P = 10;
  localparam int DEPTH = 16;

  logic clk = 0, rst = 1;
  logic cfg_enable = 0, cfg_clear = 0;
  logic [4:0] cfg_level = 5'd4;
  logic wr_valid = 0;
  logic [31:0] wr_data = '0;
  logic ser_pop = 0;
  logic [15:0] sample_out;
  logic sample_right, sample_valid, empty, dma_req, overflow, underflow;
  logic [4:0] free_count;

  audio_tx_fifo u0 (.*);

  always #(P/2) clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;
  logic [16:0] exp_q[$];
  logic [31:0] mdat[$];
  int mcnt = 0;
  bit mright = 0;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(bit wv, logic [31:0] wd, bit p, bit c);
    bit wacc, racc;
    logic [31:0] w;
    @(negedge clk);
    wr_valid = wv; wr_data = wd; ser_pop = p; cfg_clear = c;
    wacc = wv && !c && mcnt < DEPTH;
    racc = 0;
    if (c) begin
      mcnt = 0; mdat.delete(); exp_q.delete(); mright = 0;
    end else if (p && cfg_enable) begin
      if (!mright) begin
        if (mcnt > 0) begin
          w = mdat.pop_front(); racc = 1;
          exp_q.push_back({1'b0, w[15:0]});
          exp_q.push_back({1'b1, w[31:16]});
        end else begin
          exp_q.push_back({1'b0, 16'h0});
          exp_q.push_back({1'b1, 16'h0});
        end
      end
      mright = !mright;
    end
    if (racc) mcnt--;
    if (wacc) begin mdat.push_back(wd); mcnt++; end
  endtask

  task automatic idle(); cyc(0, '0, 0, 0); #1; endtask

  // scoreboard monitor: R3 ordering and channel tag
  initial forever begin
    logic [16:0] e;
    @(posedge clk); #1;
    if (!rst && sample_valid) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R7 unexpected sample actual=%0d expected=none", sample_out);
      end else begin
        e = exp_q.pop_front();
        chk("R3 sample", sample_out, e[15:0]);
        chk("R3 channel", sample_right, e[16]);
      end
    end
  end

  initial begin
    #(P*200000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    chk("R1 empty", empty, 1);
    chk("R1 free", free_count, 16);
    chk("R1 ovf", overflow, 0);
    chk("R1 unf", underflow, 0);
    chk("R1 valid", sample_valid, 0);

    // R7 prefill while disabled, pops ignored
    for (int i = 0; i < 3; i++) cyc(1, 32'h1000_0100 + i * 32'h0101_0101, 0, 0);
    idle();
    chk("R2 free after 3 writes", free_count, 13);
    chk("R2 empty", empty, 0);
    cyc(0, '0, 1, 0); idle(); idle();
    chk("R7 free unchanged", free_count, 13);

    // R3 drain in order
    cfg_enable = 1;
    for (int i = 0; i < 6; i++) begin cyc(0, '0, 1, 0); idle(); end
    idle();
    chk("R3 drained free", free_count, 16);
    chk("R3 drained empty", empty, 1);
    chk("R3 queue used", exp_q.size(), 0);

    // R4 threshold sweep while filling
    for (int i = 0; i < 16; i++) begin
      cyc(1, {16'hA000 + 16'(i), 16'h5000 + 16'(i)}, 0, 0); idle();
      chk("R2 free count", free_count, 15 - i);
      chk("R4 req at level 4", dma_req, (15 - i) >= 4);
    end
    cfg_level = 5'd0; #1; chk("R4 level 0 full", dma_req, 1);
    cfg_level = 5'd4; #1; chk("R4 full no req", dma_req, 0);

    // R5 overflow
    cyc(1, 32'hDEAD_BEEF, 0, 0); idle();
    chk("R5 ovf", overflow, 1);
    chk("R5 free", free_count, 0);
    for (int i = 0; i < 32; i++) begin cyc(0, '0, 1, 0); idle(); end
    idle();
    chk("R5 ovf sticky", overflow, 1);
    chk("R5 no extra word", exp_q.size(), 0);
    cfg_level = 5'd16; #1; chk("R4 level 16 empty", dma_req, 1);
    cfg_level = 5'd4;

    // R6 underflow
    cyc(0, '0, 1, 0); idle();
    cyc(0, '0, 1, 0); idle(); idle();
    chk("R6 unf", underflow, 1);
    chk("R6 free", free_count, 16);

    // R8 clear mid-frame with simultaneous write
    cyc(1, 32'h2222_1111, 0, 0);
    cyc(1, 32'h4444_3333, 0, 0); idle();
    cyc(0, '0, 1, 0); idle(); idle();
    cyc(1, 32'h9999_8888, 0, 1); idle();
    chk("R8 empty", empty, 1);
    chk("R8 free", free_count, 16);
    chk("R8 ovf cleared", overflow, 0);
    chk("R8 unf cleared", underflow, 0);
    cyc(1, 32'h6666_5555, 0, 0); idle();
    cyc(0, '0, 1, 0); idle(); idle();
    cyc(0, '0, 1, 0); idle(); idle();

    // R9 simultaneous write and pop
    cyc(1, 32'h0B0B_0A0A, 0, 0);
    cyc(1, 32'h0D0D_0C0C, 0, 0); idle();
    chk("R9 before", free_count, 14);
    cyc(1, 32'h0F0F_0E0E, 1, 0); idle();
    chk("R9 free kept", free_count, 14);
    for (int i = 0; i < 5; i++) begin cyc(0, '0, 1, 0); idle(); end
    idle(); idle();
    chk("R9 all out", exp_q.size(), 0);
    chk("R9 empty", empty, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule